// File: doc/BRIEF.md
# Interrupt and Trap Entry Sequencer

This block is the sequencing core of a small stored-program control unit. It alternates a fetch cycle and an execute cycle against one single-port word memory. Fetch copies the word at the program counter into the instruction register. Execute advances the program counter by one instruction step. The memory is read combinationally: the read data belongs to the address presented in the same cycle. Each access takes one cycle.

Right after each fetch, the block checks for an interrupt. It takes one only when the request line is high and interrupts are armed. On entry it disarms interrupts, stores the program counter in a fixed save word, and loads the program counter from the next word, which holds the handler address. It then fetches again from the handler. A trap strobe during an execute cycle does its whole job in that one cycle: it raises supervisor mode and loads the program counter from a handler table indexed by the trap number. A halt seen in an execute cycle freezes the sequencer until reset.

Top module: `entry_seq`

## Requirements
- R1: While reset is held, the program counter is the start address (default 0x010), the instruction register is 0, interrupts are disarmed and the mode bit is 0 (user). Supervisor mode is 1.
- R2: Each instruction takes two cycles. The fetch edge loads the instruction register from memory at the program counter. The following execute edge adds the step (default 1) to the program counter.
- R3: The interrupt is tested only on the fetch edge and is taken only when the request is 1 and the enable flag is 1. A request while disarmed has no effect on the program counter or on the fetch/execute rhythm.
- R4: The enable flag drops to 0 on the fetch edge that takes the interrupt. A request that stays high does not start a second entry until interrupts are re-armed.
- R5: The cycle after the taking edge writes the program counter to word 0. That value is the address of the fetched and abandoned instruction. No other cycle writes memory.
- R6: The next cycle reads word 1 into the program counter. Fetching then resumes from that address.
- R7: A trap strobe in an execute cycle with a number n in 1..TRAP_CNT (default 8) sets the mode bit to 1. On the same edge it loads the program counter from word 1000+n.
- R8: A trap number of 0 or above TRAP_CNT is ignored. The program counter advances normally and the mode bit is unchanged.
- R9: Halt high in an execute cycle stops the sequencer. From then on the program counter and instruction register keep their values and memory is not written until reset.
- R10: The enable-set input arms interrupts on the next edge, except on an edge that takes an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Interrupt request |
| ien_set | input | 1 | Arm interrupts |
| trap_stb | input | 1 | Trap strobe, used in execute cycles |
| trap_num | input | TNW (4) | Trap handler number |
| halt | input | 1 | Halt request, used in execute cycles |
| mem_addr | output | AW (12) | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DW (16) | Memory write data |
| mem_rdata | input | DW (16) | Memory read data for mem_addr, same cycle |
| pc | output | AW (12) | Program counter |
| ir | output | DW (16) | Instruction register |
| ien | output | 1 | Interrupt enable flag |
| sup_mode | output | 1 | 1 = supervisor, 0 = user |

## Verification
The properties assume that memory returns the word for the current address within the same cycle. They also assume that the vector and table words hold addresses in range. Trap and halt are meaningful only in execute cycles, and enable-set is never pulsed inside an interrupt entry. The stimulus changes inputs only just after a clock edge. It raises trap and halt only when the sequencer has just entered an execute cycle, and it pulses enable-set only outside an interrupt entry. The memory model is a pure function of the address, with the save word captured separately.

// File: rtl/entry_seq_pkg.sv
package entry_seq_pkg;
  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,
    ST_EXEC  = 3'd1,
    ST_SAVE  = 3'd2,
    ST_VEC   = 3'd3,
    ST_HALT  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/entry_fsm.sv
module entry_fsm
  import entry_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq,
  input  logic       ien,
  input  logic       halt,
  output seq_state_e state,
  output logic       take_irq
);
  seq_state_e state_nx;

  // Interrupt is sampled only on the edge that ends a fetch
  assign take_irq = (state == ST_FETCH) && irq && ien;

  always_comb begin
    state_nx = state;
    case (state)
      ST_FETCH: state_nx = take_irq ? ST_SAVE : ST_EXEC;
      ST_EXEC:  state_nx = halt ? ST_HALT : ST_FETCH;
      ST_SAVE:  state_nx = ST_VEC;
      ST_VEC:   state_nx = ST_FETCH;
      ST_HALT:  state_nx = ST_HALT;
      default:  state_nx = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= state_nx;
  end

  // R5/R6: the entry runs save then vector then refetch without a gap
  assert_entry_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SAVE) |=> (state == ST_VEC));
  assert_vec_refetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VEC) |=> (state == ST_FETCH));
  assert_halt_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |=> (state == ST_HALT));
endmodule

// File: rtl/entry_flags.sv
module entry_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic take_irq,
  input  logic ien_set,
  input  logic trap_hit,
  output logic ien,
  output logic sup_mode
);
  logic ien_nx, mode_nx;
  logic ien_en, mode_en;

  always_comb begin
    ien_en  = take_irq || ien_set;
    ien_nx  = !take_irq;
    mode_en = trap_hit;
    mode_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien      <= 1'b0;
      sup_mode <= 1'b0;
    end else begin
      if (ien_en)  ien      <= ien_nx;
      if (mode_en) sup_mode <= mode_nx;
    end
  end

  assert_take_clears_ien_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> !ien);
  assert_set_arms_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_set && !take_irq) |=> ien);
  assert_trap_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_hit |=> sup_mode);
endmodule

// File: rtl/entry_seq.sv
module entry_seq
  import entry_seq_pkg::*;
#(
  parameter int AW         = 12,
  parameter int DW         = 16,
  parameter int TNW        = 4,
  parameter int START_ADDR = 16,
  parameter int STEP       = 1,
  parameter int SAVE_ADDR  = 0,
  parameter int VEC_ADDR   = 1,
  parameter int TRAP_BASE  = 1000,
  parameter int TRAP_CNT   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           irq,
  input  logic           ien_set,
  input  logic           trap_stb,
  input  logic [TNW-1:0] trap_num,
  input  logic           halt,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_we,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic [AW-1:0]  pc,
  output logic [DW-1:0]  ir,
  output logic           ien,
  output logic           sup_mode
);
  localparam logic [AW-1:0] PC_RST   = AW'(START_ADDR);
  localparam logic [AW-1:0] PC_STEP  = AW'(STEP);
  localparam logic [AW-1:0] SAVE_W   = AW'(SAVE_ADDR);
  localparam logic [AW-1:0] VEC_W    = AW'(VEC_ADDR);
  localparam logic [AW-1:0] TBL_BASE = AW'(TRAP_BASE);

  seq_state_e     state;
  logic           take_irq;
  logic           trap_ok, trap_hit;
  logic [AW-1:0]  pc_nx, rd_addr;
  logic           pc_en, ir_en;

  assign rd_addr  = mem_rdata[AW-1:0];
  assign trap_ok  = (trap_num != '0) && (int'(trap_num) <= TRAP_CNT);
  assign trap_hit = (state == ST_EXEC) && !halt && trap_stb && trap_ok;

  entry_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .ien      (ien),
    .halt     (halt),
    .state    (state),
    .take_irq (take_irq)
  );

  entry_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_irq (take_irq),
    .ien_set  (ien_set),
    .trap_hit (trap_hit),
    .ien      (ien),
    .sup_mode (sup_mode)
  );

  // Memory port: one access per state
  always_comb begin
    mem_addr  = pc;
    mem_we    = 1'b0;
    mem_wdata = '0;
    case (state)
      ST_EXEC: if (trap_hit) mem_addr = TBL_BASE + AW'(trap_num);
      ST_SAVE: begin
        mem_addr  = SAVE_W;
        mem_we    = 1'b1;
        mem_wdata = DW'(pc);
      end
      ST_VEC:  mem_addr = VEC_W;
      default: mem_addr = pc;
    endcase
  end

  // Program counter and instruction register next values
  always_comb begin
    pc_en = 1'b0;
    pc_nx = pc;
    ir_en = (state == ST_FETCH);
    case (state)
      ST_EXEC: if (!halt) begin
        pc_en = 1'b1;
        pc_nx = trap_hit ? rd_addr : pc + PC_STEP;
      end
      ST_VEC: begin
        pc_en = 1'b1;
        pc_nx = rd_addr;
      end
      default: pc_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= PC_RST;
      ir <= '0;
    end else begin
      if (pc_en) pc <= pc_nx;
      if (ir_en) ir <= mem_rdata;
    end
  end

  assert_save_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> (mem_we && mem_addr == SAVE_W && mem_wdata == DW'($past(pc))));
  assert_vector_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VEC) |=> (pc == $past(rd_addr)));
  assert_trap_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_hit |=> (sup_mode && pc == $past(rd_addr)));
  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && !halt && !trap_hit) |=> (pc == $past(pc) + PC_STEP));
  assert_bad_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && !halt && trap_stb && !trap_ok) |=> $stable(sup_mode));
  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |=> ($stable(pc) && $stable(ir) && !mem_we));
  assert_irq_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH && !(irq && ien)) |=> !mem_we);
endmodule

// File: tb/entry_seq_test.sv
module entry_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0, ien_set = 1'b0, trap_stb = 1'b0, halt = 1'b0;
  logic [3:0]  trap_num = 4'd0;
  logic [11:0] mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata, mem_rdata;
  logic [11:0] pc;
  logic [15:0] ir;
  logic        ien, sup_mode;
  logic [15:0] saved0 = 16'hFFFF;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  typedef struct {
    logic [11:0] p;
    logic [15:0] i;
    bit          e;
    bit          m;
    bit          chk_sv;
    logic [15:0] sv;
    string       tag;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  entry_seq uut (
    .clk(clk), .rst_n(rst_n), .irq(irq), .ien_set(ien_set),
    .trap_stb(trap_stb), .trap_num(trap_num), .halt(halt),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pc(pc), .ir(ir), .ien(ien), .sup_mode(sup_mode)
  );

  // Memory image: word 1 = handler 0x800, words 1001..1008 = 0x300+8n, else 0xC<addr>
  function automatic logic [15:0] imem(input logic [11:0] a);
    if (a == 12'd1) return 16'h0800;
    if (a >= 12'd1001 && a <= 12'd1008) return 16'h0300 + 16'((a - 12'd1000) * 8);
    return {4'hC, a};
  endfunction

  assign mem_rdata = imem(mem_addr);

  always @(posedge clk) if (mem_we) saved0 <= (mem_addr == 12'd0) ? mem_wdata : 16'hDEAD;

  // Monitor: compare every pending expectation away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (pc !== it.p || ir !== it.i || ien !== it.e || sup_mode !== it.m ||
          (it.chk_sv && saved0 !== it.sv)) begin
        n_bad++;
        $display("FAIL %s: pc=%h ir=%h ien=%b mode=%b save=%h expected pc=%h ir=%h ien=%b mode=%b save=%h",
                 it.tag, pc, ir, ien, sup_mode, saved0, it.p, it.i, it.e, it.m, it.sv);
      end
    end
  end

  task automatic step(input logic [11:0] p, input logic [15:0] i, input bit e,
                      input bit m, input string tag);
    @(posedge clk); #1;
    q.push_back('{p, i, e, m, 1'b0, 16'h0, tag});
  endtask

  task automatic step_sv(input logic [11:0] p, input logic [15:0] i, input bit e,
                         input bit m, input logic [15:0] sv, input string tag);
    @(posedge clk); #1;
    q.push_back('{p, i, e, m, 1'b1, sv, tag});
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1 q.push_back('{12'h010, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0, "R1 reset state"});
    @(negedge clk) rst_n = 1'b1;
    step(12'h010, 16'hC010, 0, 0, "R2 fetch");
    step(12'h011, 16'hC010, 0, 0, "R2 advance");
    irq = 1'b1;
    step(12'h011, 16'hC011, 0, 0, "R3 request while disarmed");
    step(12'h012, 16'hC011, 0, 0, "R3 no entry");
    irq = 1'b0; ien_set = 1'b1;
    step(12'h012, 16'hC012, 1, 0, "R10 arm");
    ien_set = 1'b0;
    step(12'h013, 16'hC012, 1, 0, "R10 stays armed");
    irq = 1'b1;
    step(12'h013, 16'hC013, 0, 0, "R4 taken clears enable");
    step_sv(12'h013, 16'hC013, 0, 0, 16'h0013, "R5 pc saved to word 0");
    step(12'h800, 16'hC013, 0, 0, "R6 vector loaded");
    step(12'h800, 16'hC800, 0, 0, "R4 no second entry");
    irq = 1'b0;
    step(12'h801, 16'hC800, 0, 0, "R6 handler advances");
    step(12'h801, 16'hC801, 0, 0, "R2 handler fetch");
    trap_stb = 1'b1; trap_num = 4'd0;
    step(12'h802, 16'hC801, 0, 0, "R8 trap number 0");
    trap_stb = 1'b0;
    step(12'h802, 16'hC802, 0, 0, "R8 fetch after");
    trap_stb = 1'b1; trap_num = 4'd9;
    step(12'h803, 16'hC802, 0, 0, "R8 trap number 9");
    trap_stb = 1'b0;
    step(12'h803, 16'hC803, 0, 0, "R8 fetch after");
    trap_stb = 1'b1; trap_num = 4'd3;
    step(12'h318, 16'hC803, 0, 1, "R7 trap 3");
    trap_stb = 1'b0;
    step(12'h318, 16'hC318, 0, 1, "R7 handler fetch");
    trap_stb = 1'b1; trap_num = 4'd8;
    step(12'h340, 16'hC318, 0, 1, "R7 trap 8 upper bound");
    trap_stb = 1'b0;
    step(12'h340, 16'hC340, 0, 1, "R7 handler fetch");
    halt = 1'b1; irq = 1'b1;
    step(12'h340, 16'hC340, 0, 1, "R9 halt");
    halt = 1'b0;
    for (int k = 0; k < 3; k++) step_sv(12'h340, 16'hC340, 0, 1, 16'h0013, "R9 held");
    @(negedge clk); #1;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule